// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counter Timer Unit

This block groups two or three independent down-counting timer channels behind one word-addressed register window. Each channel has a reload value, a live counter and a control word. The control word picks a clock divider and holds an interrupt enable and an underflow flag. A running channel steps its counter down once per divided tick. When a tick finds the counter at zero, the counter loads the reload value again and the underflow flag is set. Each channel drives its own interrupt line, which is high while both its flag and its enable are set.

One shared start register turns the channels on and off, one bit per channel. A parameter decides whether the third channel exists. The third channel has an extra word in its window, which reads as zero. A second parameter adds a one-bit output-control register at the bottom of the map. An address decoder sends each access to the shared registers or to one channel. Any access that hits no register reads as zero, changes nothing, and pulses an error strobe.

Top module: `tmr_unit`

## Requirements
- R1: After the synchronous active-high reset, the start register reads 0, every reload and counter register reads 0xFFFFFFFF, every control word reads 0, every interrupt line is low and the output-control bit is 0.
- R2: Word-aligned byte offsets map as follows: 0x04 start, channel 0 at 0x08 (reload), 0x0C (counter), 0x10 (control), channel 1 at 0x14/0x18/0x1C in the same order, and channel 2 at 0x20/0x24/0x28 plus 0x2C, a slot that accepts writes without effect and reads 0. Written reload, counter and control values read back at their offsets.
- R3: Bit i of the start register runs channel i, and the register reads back its stored bits. While a channel's bit is 0, its counter holds its value.
- R4: Control bits [2:0] select a divide-by of 4, 16, 64, 256 or 1024 for the values 0 to 4. After a write sets the start bit, a channel holding count N with reload N and divide D raises its flag after D*(N+1) clocks. Values 5 to 7 stop counting.
- R5: When a tick finds the counter at 0, the counter takes the reload value and control bit 8, the underflow flag, becomes 1.
- R6: A control write with bit 8 at 0 clears the flag, and a write with bit 8 at 1 leaves it unchanged.
- R7: The interrupt line of each channel is high exactly while that channel's flag (control bit 8) and enable (control bit 5) are both 1, and it is independent of the other channels.
- R8: The output-control register at offset 0x00 stores only bit 0. It drives the out_ctl pin, and its other bits read 0.
- R9: An access to an unmapped offset (one with address bits [1:0] not 00, one above the last channel word, or 0x00 without the output-control register) reads 0 and writes nothing. bus_err is high for exactly the one cycle after such an access and low after every valid access or idle cycle.
- R10: With the third channel left out, offsets 0x20 and up are unmapped and start bit 2 is dropped, so it reads 0. Without the output-control register, offset 0x00 is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock shared by all channels |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte offset inside the window |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid the cycle after a read, else 0 |
| bus_err | output | 1 | One-cycle strobe after an unmapped access |
| irq | output | NCH (3) | Per-channel interrupt lines |
| out_ctl | output | 1 | Stored output-control bit |

## Verification
The bench measures the exact clock count from setting a start bit to the rise of the interrupt for two divider settings. A prescaler that starts one phase off, or an underflow that fires one tick early or late, changes that count. It stops a channel in the middle of a run and expects an exact residual count, then checks that the count stays put while stopped and under a reserved divider. A counter that drifts while stopped would fail those checks. The irregular 0x14 and 0x20 window bases, the read-as-zero capture slot and misaligned offsets are all probed, because a decoder that aliases by offset would corrupt a neighbour's counter. A second instance built with two channels and no output-control register checks that the missing registers really are missing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } chreg_e;

  typedef struct packed {
    logic       valid;
    logic       outctl;
    logic       start;
    logic       chan;
    logic [1:0] ch_idx;
    chreg_e     reg_sel;
  } dec_t;

  // word indexes of the shared registers
  localparam int W_OUTCTL = 0;
  localparam int W_START  = 1;

  // control word field positions
  localparam int CTL_IE_BIT   = 5;
  localparam int CTL_FLAG_BIT = 8;

  // first word index of each channel window (byte offsets 0x08, 0x14, 0x20)
  function automatic int ch_base(input int c);
    case (c)
      0:       return 2;
      1:       return 5;
      default: return 8;
    endcase
  endfunction

  // the last channel carries one extra word
  function automatic int ch_words(input int c);
    return (c == 2) ? 4 : 3;
  endfunction

  function automatic logic sel_ok(input logic [2:0] sel);
    return sel <= 3'd4;
  endfunction

  // log2 of the divide ratio: 2, 4, 6, 8, 10
  function automatic int div_log2(input logic [2:0] sel);
    return 2 * int'(sel) + 2;
  endfunction

  // prescaler terminal value for a legal select
  function automatic int pre_last(input logic [2:0] sel);
    return (1 << div_log2(sel)) - 1;
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [2:0] sel,
                                            input logic ie,
                                            input logic flag);
    logic [15:0] w;
    w = '0;
    w[2:0] = sel;
    w[CTL_IE_BIT] = ie;
    w[CTL_FLAG_BIT] = flag;
    return w;
  endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int AW         = 8,
  parameter bit THREE_CH   = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  localparam int WW  = AW - 2;
  localparam int NCH = THREE_CH ? 3 : 2;

  logic [WW-1:0] widx;
  logic [WW-1:0] off;

  always_comb begin
    widx = addr[AW-1:2];
    dec  = '0;
    off  = '0;
    if (addr[1:0] == 2'b00) begin
      if (widx == WW'(W_OUTCTL)) begin
        dec.valid  = HAS_OUTCTL;
        dec.outctl = HAS_OUTCTL;
      end else if (widx == WW'(W_START)) begin
        dec.valid = 1'b1;
        dec.start = 1'b1;
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (widx >= WW'(ch_base(c)) &&
              widx <  WW'(ch_base(c) + ch_words(c))) begin
            off         = widx - WW'(ch_base(c));
            dec.valid   = 1'b1;
            dec.chan    = 1'b1;
            dec.ch_idx  = 2'(c);
            dec.reg_sel = chreg_e'(off[1:0]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PW-1:0] pre_q;
  logic          legal;

  assign legal = sel_ok(sel);
  assign tick  = run && legal && (pre_q == PW'(pre_last(sel)));

  always_ff @(posedge clk) begin
    if (rst || !run || restart || !legal) pre_q <= '0;
    else if (tick)                        pre_q <= '0;
    else                                  pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          wr,
  input  chreg_e        rsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          tick_o,
  output logic          uf_o,
  output logic          cnt_wr_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] reload_o
);
  logic [DW-1:0] reload_q, cnt_q;
  logic [2:0]    sel_q;
  logic          ie_q, flag_q;
  logic          tick, uf, ctl_wr;

  assign ctl_wr   = wr && (rsel == REG_CTRL);
  assign cnt_wr_o = wr && (rsel == REG_COUNT);

  tmr_prescaler #(.PW(PW)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (ctl_wr),
    .sel     (sel_q),
    .tick    (tick)
  );

  assign uf = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      cnt_q    <= '1;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr && rsel == REG_RELOAD) reload_q <= wdata;
      if (cnt_wr_o)   cnt_q <= wdata;
      else if (uf)    cnt_q <= reload_q;
      else if (tick)  cnt_q <= cnt_q - 1'b1;
      if (ctl_wr) begin
        sel_q <= wdata[2:0];
        ie_q  <= wdata[CTL_IE_BIT];
      end
      if (uf)                                 flag_q <= 1'b1;
      else if (ctl_wr && !wdata[CTL_FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (rsel)
      REG_RELOAD: rdata = reload_q;
      REG_COUNT:  rdata = cnt_q;
      REG_CTRL:   rdata = DW'(ctrl_word(sel_q, ie_q, flag_q));
      default:    rdata = '0;
    endcase
  end

  assign irq      = flag_q && ie_q;
  assign tick_o   = tick;
  assign uf_o     = uf;
  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 8,
  parameter int PW         = 10,
  parameter bit THREE_CH   = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1,
  localparam int NCH       = THREE_CH ? 3 : 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_err,
  output logic [NCH-1:0] irq,
  output logic           out_ctl
);
  dec_t           dec;
  logic           wr_acc, rd_acc, acc_bad;
  logic           wr_start, wr_outctl;
  logic [NCH-1:0] run_q;
  logic [NCH-1:0] ch_wr, ch_tick, ch_uf, ch_cnt_wr;
  logic [DW-1:0]  ch_rdata [NCH];
  logic [NCH*DW-1:0] cnt_flat, reload_flat;
  logic [DW-1:0]  rd_mux;

  tmr_decode #(.AW(AW), .THREE_CH(THREE_CH), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_acc    = bus_en && bus_we;
  assign rd_acc    = bus_en && !bus_we;
  assign acc_bad   = bus_en && !dec.valid;
  assign wr_start  = wr_acc && dec.start;
  assign wr_outctl = wr_acc && dec.outctl;

  // shared start register: one run bit per channel
  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (wr_start) run_q <= bus_wdata[NCH-1:0];
  end

  generate
    if (HAS_OUTCTL) begin : g_oc
      logic oc_q;
      always_ff @(posedge clk) begin
        if (rst)            oc_q <= 1'b0;
        else if (wr_outctl) oc_q <= bus_wdata[0];
      end
      assign out_ctl = oc_q;
    end else begin : g_no_oc
      assign out_ctl = 1'b0;
    end
  endgenerate

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign ch_wr[i] = wr_acc && dec.chan && (dec.ch_idx == 2'(i));
      tmr_channel #(.DW(DW), .PW(PW)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q[i]),
        .wr       (ch_wr[i]),
        .rsel     (dec.reg_sel),
        .wdata    (bus_wdata),
        .rdata    (ch_rdata[i]),
        .irq      (irq[i]),
        .tick_o   (ch_tick[i]),
        .uf_o     (ch_uf[i]),
        .cnt_wr_o (ch_cnt_wr[i]),
        .cnt_o    (cnt_flat[i*DW +: DW]),
        .reload_o (reload_flat[i*DW +: DW])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (dec.outctl)     rd_mux = DW'(out_ctl);
    else if (dec.start) rd_mux = DW'(run_q);
    else if (dec.chan) begin
      for (int i = 0; i < NCH; i++)
        if (dec.ch_idx == 2'(i)) rd_mux = ch_rdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_acc ? rd_mux : '0;
      bus_err   <= acc_bad;
    end
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NCH = 3,
  parameter int DW  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_err,
  input logic              acc_bad,
  input logic              wr_start,
  input logic              wr_outctl,
  input logic [NCH-1:0]    run_q,
  input logic              out_ctl,
  input logic [NCH-1:0]    ch_tick,
  input logic [NCH-1:0]    ch_uf,
  input logic [NCH-1:0]    ch_cnt_wr,
  input logic [NCH*DW-1:0] cnt_flat,
  input logic [NCH*DW-1:0] reload_flat
);
  // R9: strobe only follows an unmapped access, and always does
  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(acc_bad));
  a_r9_err_follows: assert property (@(posedge clk) disable iff (rst)
    acc_bad |=> bus_err);

  // R3: enables change only through a start write
  a_r3_run_by_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(run_q) |-> $past(wr_start));

  // R8: output-control bit changes only through its own write
  a_r8_oc_by_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_ctl) |-> $past(wr_outctl));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_c
      // R4: no divided tick on a stopped channel
      a_r4_tick_needs_run: assert property (@(posedge clk) disable iff (rst)
        ch_tick[i] |-> run_q[i]);
      // R5: underflow reloads the counter
      a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (ch_uf[i] && !ch_cnt_wr[i]) |=>
          cnt_flat[i*DW +: DW] == $past(reload_flat[i*DW +: DW]));
      // R3: a stopped counter holds
      a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run_q[i] && !ch_cnt_wr[i]) |=> $stable(cnt_flat[i*DW +: DW]));
    end
  endgenerate
endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_err     (bus_err),
  .acc_bad     (acc_bad),
  .wr_start    (wr_start),
  .wr_outctl   (wr_outctl),
  .run_q       (run_q),
  .out_ctl     (out_ctl),
  .ch_tick     (ch_tick),
  .ch_uf       (ch_uf),
  .ch_cnt_wr   (ch_cnt_wr),
  .cnt_flat    (cnt_flat),
  .reload_flat (reload_flat)
);

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0, en2 = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata2;
  logic        bus_err, err2, out_ctl, oc2;
  logic [2:0]  irq;
  logic [1:0]  irq2;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // scoreboard queues, one entry per bus access
  bit          q_rd  [$];
  logic [31:0] q_exp [$];
  bit          q_bad [$];
  string       q_req [$];

  always #4 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq), .out_ctl(out_ctl)
  );

  tmr_unit #(.THREE_CH(1'b0), .HAS_OUTCTL(1'b0)) u_tmr_unit_two (
    .clk(clk), .rst(rst), .bus_en(en2), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
    .bus_err(err2), .irq(irq2), .out_ctl(oc2)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [7:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input bit bad, input string req);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    q_rd.push_back(!we); q_exp.push_back(exp);
    q_bad.push_back(bad); q_req.push_back(req);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    acc(1'b1, a, d, '0, 1'b0, req);
  endtask
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    acc(1'b0, a, '0, exp, 1'b0, req);
  endtask

  // direct access on the two-channel instance
  task automatic acc2(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] exp, input bit bad, input string req);
    @(negedge clk);
    en2 = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    en2 = 1'b0; bus_we = 1'b0;
    chk(err2 == bad, {req, " err"}, 32'(err2), 32'(bad));
    if (!we) chk(rdata2 == exp, {req, " data"}, rdata2, exp);
  endtask

  // monitor: pop and compare the access registered at each edge
  initial begin
    forever begin
      bit was_acc;
      @(posedge clk);
      was_acc = bus_en;
      #2;
      if (!rst) begin
        if (was_acc) begin
          if (q_rd.size() == 0) chk(1'b0, "scoreboard empty", 0, 0);
          else begin
            bit r, b; logic [31:0] e; string t;
            r = q_rd.pop_front(); e = q_exp.pop_front();
            b = q_bad.pop_front(); t = q_req.pop_front();
            chk(bus_err == b, {t, " err"}, 32'(bus_err), 32'(b));
            if (r) chk(bus_rdata == e, {t, " data"}, bus_rdata, e);
          end
        end else begin
          chk(bus_err == 1'b0, "R9 idle err", 32'(bus_err), 0);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk(irq == 3'b000, "R1 irq", 32'(irq), 0);
    chk(out_ctl == 1'b0, "R1 out_ctl", 32'(out_ctl), 0);
    rd(8'h04, 32'h0, "R1 start");
    rd(8'h08, 32'hFFFF_FFFF, "R1 reload0");
    rd(8'h0C, 32'hFFFF_FFFF, "R1 count0");
    rd(8'h10, 32'h0, "R1 ctrl0");
    rd(8'h00, 32'h0, "R1 outctl");

    // R8 output-control
    wr(8'h00, 32'hFFFF_FFFF, "R8");
    rd(8'h00, 32'h1, "R8 readback");
    chk(out_ctl == 1'b1, "R8 pin", 32'(out_ctl), 1);
    wr(8'h00, 32'h0, "R8");
    rd(8'h00, 32'h0, "R8 clear");

    // R2 address map and readback
    wr(8'h08, 32'h0000_1234, "R2"); rd(8'h08, 32'h0000_1234, "R2 reload0");
    wr(8'h18, 32'h0000_ABCD, "R2"); rd(8'h18, 32'h0000_ABCD, "R2 count1");
    wr(8'h24, 32'h0000_0055, "R2"); rd(8'h24, 32'h0000_0055, "R2 count2");
    wr(8'h2C, 32'hDEAD_BEEF, "R2"); rd(8'h2C, 32'h0, "R2 capture slot");
    wr(8'h28, 32'h0000_0003, "R2"); rd(8'h28, 32'h0000_0003, "R2 ctrl2");
    rd(8'h0C, 32'hFFFF_FFFF, "R2 count0 untouched");

    // R9 unmapped offsets
    acc(1'b0, 8'h30, '0, 32'h0, 1'b1, "R9 above map");
    acc(1'b0, 8'h0D, '0, 32'h0, 1'b1, "R9 misaligned read");
    acc(1'b1, 8'h0D, 32'h9999, '0, 1'b1, "R9 misaligned write");
    acc(1'b1, 8'h3C, 32'h7777, '0, 1'b1, "R9 write above map");
    rd(8'h0C, 32'hFFFF_FFFF, "R9 no write effect");

    // R3 start readback
    wr(8'h04, 32'h7, "R3"); rd(8'h04, 32'h7, "R3 start bits");
    wr(8'h04, 32'h0, "R3"); rd(8'h04, 32'h0, "R3 start clear");

    // R3/R4 exact residual count, divide 4, stopped after 42 edges
    wr(8'h28, 32'h0, "R4");
    wr(8'h24, 32'd100, "R4");
    wr(8'h04, 32'h4, "R3");
    repeat (40) @(negedge clk);
    wr(8'h04, 32'h0, "R3");
    rd(8'h24, 32'd90, "R4 residual count");
    repeat (20) @(negedge clk);
    rd(8'h24, 32'd90, "R3 frozen while stopped");

    // R4 reserved select stops counting
    wr(8'h28, 32'h5, "R4");
    wr(8'h04, 32'h4, "R4");
    repeat (100) @(negedge clk);
    wr(8'h04, 32'h0, "R4");
    rd(8'h24, 32'd90, "R4 reserved divider");

    // R4/R5/R7 channel 0, divide 4, count 3 -> 16 clocks
    wr(8'h10, 32'h20, "R7");
    wr(8'h08, 32'd3, "R5");
    wr(8'h0C, 32'd3, "R5");
    chk(irq[0] == 1'b0, "R7 irq0 idle", 32'(irq[0]), 0);
    wr(8'h04, 32'h1, "R4");
    k = 0;
    while (!irq[0] && k < 5000) begin @(negedge clk); k++; end
    chk(k == 16, "R4 div4 latency", k, 16);
    chk(irq[2:1] == 2'b00, "R7 other lines low", 32'(irq[2:1]), 0);
    wr(8'h04, 32'h0, "R3");

    // channel 1, divide 16, count 1 -> 32 clocks
    wr(8'h1C, 32'h21, "R7");
    wr(8'h14, 32'd1, "R5");
    wr(8'h18, 32'd1, "R5");
    wr(8'h04, 32'h2, "R4");
    k = 0;
    while (!irq[1] && k < 5000) begin @(negedge clk); k++; end
    chk(k == 32, "R4 div16 latency", k, 32);
    wr(8'h04, 32'h0, "R3");
    rd(8'h18, 32'd1, "R5 reloaded count");
    rd(8'h1C, 32'h121, "R5 flag set");

    // R6 flag clear rules
    wr(8'h1C, 32'h121, "R6");
    rd(8'h1C, 32'h121, "R6 flag kept");
    chk(irq[1] == 1'b1, "R6 irq1 kept", 32'(irq[1]), 1);
    wr(8'h1C, 32'h021, "R6");
    chk(irq[1] == 1'b0, "R6 irq1 cleared", 32'(irq[1]), 0);
    rd(8'h1C, 32'h021, "R6 flag cleared");

    // R7 enable masks the line while flag stays
    chk(irq[0] == 1'b1, "R7 irq0 high", 32'(irq[0]), 1);
    wr(8'h10, 32'h100, "R7");
    chk(irq[0] == 1'b0, "R7 irq0 masked", 32'(irq[0]), 0);
    rd(8'h10, 32'h100, "R7 flag retained");

    // R10 two-channel, no output-control
    acc2(1'b0, 8'h20, '0, 32'h0, 1'b1, "R10 no third channel");
    acc2(1'b1, 8'h04, 32'h7, '0, 1'b0, "R10 start write");
    acc2(1'b0, 8'h04, '0, 32'h3, 1'b0, "R10 start bit2 dropped");
    acc2(1'b0, 8'h00, '0, 32'h0, 1'b1, "R10 no outctl");
    acc2(1'b1, 8'h04, 32'h0, '0, 1'b0, "R10 stop");
    chk(oc2 == 1'b0, "R10 outctl pin", 32'(oc2), 0);

    repeat (4) @(negedge clk);
    chk(q_rd.size() == 0, "scoreboard drained", q_rd.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule